// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block picks which of eight interrupt lines should be presented to a processor. Each line that is pending and not masked competes for service. Priority is relative to a rotatable base: the line at the base has the top priority and the ones after it, wrapping around, rank lower. The winner is compared with the highest-ranked line already in service. The interrupt output is raised only when the winner strictly outranks that line, so a lower- or equal-priority request waits until service of the higher one ends.

The block holds the in-service register and the priority base. An acknowledge strobe marks the presented line as in service. A command byte, qualified by a valid strobe, ends service and rotates the priority. It can end service of the top in-service line or of a named line, move the base, and set or clear a rotate-on-auto-EOI flag. A nested-mode flag and a primary-instance flag together exclude the cascade line (line 2) from the current-priority comparison. This lets a secondary controller chained on that line pass a higher-priority request through while an earlier one is still being served.

Top module: `prio_resolver`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `isr_o` is 0, `irq_valid_o` is 0, `irq_line_o` is 0 and `rot_aeoi_o` is 0. The priority base resets to 0.
- R2: Relative priority p (0 is highest) maps to line (p + base) mod 8. Among the lines set in `pend_i & ~mask_i`, the one with the smallest p wins, and its number is reported on `irq_line_o`.
- R3: `irq_valid_o` is 1 only when the winner's relative priority is strictly smaller than that of the highest-ranked in-service line. An empty set counts as priority 8. When `irq_valid_o` is 0, `irq_line_o` reads 0.
- R4: When both `nested_i` and `primary_i` are 1, in-service bit 2 is left out of the current-priority comparison. Otherwise it counts like any other bit.
- R5: `irq_valid_o` and `irq_line_o` are registered. They reflect the inputs present at a clock edge and the in-service register and base held before that edge.
- R6: `ack_i` while `irq_valid_o` is 1 sets the in-service bit of the line on `irq_line_o` at the next edge. `ack_i` while `irq_valid_o` is 0 changes nothing.
- R7: Command code 1 (bits [7:5] = 001) clears the in-service bit of the highest-ranked in-service line. The bit-2 exclusion does not apply to this search. With nothing in service, the command has no effect.
- R8: Command code 5 does what code 1 does and also sets the base to (cleared line + 1) mod 8. With nothing in service, neither the register nor the base changes.
- R9: Command code 3 clears the in-service bit named by bits [2:0] and leaves the other bits alone. Code 7 does the same and also sets the base to (bits[2:0] + 1) mod 8.
- R10: Command code 6 sets the base to (bits[2:0] + 1) mod 8 and leaves the in-service register unchanged.
- R11: Codes 0 and 4 write bit 7 of the byte into `rot_aeoi_o`, and code 2 does nothing. A byte with bit 4 or bit 3 set is ignored, and so is any byte presented without `cmd_valid_i`.
- R12: When an acknowledge and a command fall in the same cycle, the command's clear works on the in-service register as it stood before the edge. The acknowledged bit is set after that clear, so it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 8 | Pending request vector, one bit per line |
| mask_i | input | 8 | Mask; a set bit removes the line from arbitration |
| cmd_valid_i | input | 1 | Qualifies `cmd_i` for one cycle |
| cmd_i | input | 8 | Command byte: code in [7:5], format bits [4:3], line in [2:0] |
| ack_i | input | 1 | Acknowledge of the presented line |
| nested_i | input | 1 | Special fully nested mode enable |
| primary_i | input | 1 | This instance is the primary of a cascade |
| irq_valid_o | output | 1 | Interrupt request to the processor |
| irq_line_o | output | 3 | Winning line number, 0 when no request |
| isr_o | output | 8 | In-service register |
| rot_aeoi_o | output | 1 | Rotate-on-auto-EOI flag |

## Verification
The acknowledge and an end-of-service or rotation command can land on the same edge, and both update the in-service register. The bench provokes this on purpose in two ways. It clears by name the very line being acknowledged, and it issues a non-specific end of service while a different, higher line is acknowledged. It checks that the clear used the register as it stood before the edge and that the acknowledged bit survives. A long stretch of random stimulus then drives acknowledges and commands together at random and compares every output on every clock with a behavioural model.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

    localparam int DEF_LINES = 8;
    localparam int CMD_W     = 8;
    localparam int ARG_W     = 3;

    // service command codes, taken from command byte bits [7:5]
    typedef enum logic [2:0] {
        OP_ROT_OFF   = 3'd0,
        OP_EOI_TOP   = 3'd1,
        OP_IDLE      = 3'd2,
        OP_EOI_LINE  = 3'd3,
        OP_ROT_ON    = 3'd4,
        OP_EOI_TOP_R = 3'd5,
        OP_SET_BASE  = 3'd6,
        OP_EOI_LINE_R= 3'd7
    } svc_op_e;

    typedef struct packed {
        logic         fmt_ok;   // bits [4:3] clear: this command format
        svc_op_e      op;
        logic [ARG_W-1:0] arg;
    } svc_cmd_t;

    function automatic svc_cmd_t decode_cmd(input logic [CMD_W-1:0] b);
        svc_cmd_t d;
        d.fmt_ok = (b[4:3] == 2'b00);
        d.op     = svc_op_e'(b[7:5]);
        d.arg    = b[ARG_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/prio_scan.sv
// Finds the smallest relative priority set in a vector, counting from a
// rotatable base. Returns NUM_LINES as the "empty" value.
module prio_scan #(
    parameter int NUM_LINES = 8,
    localparam int LW = $clog2(NUM_LINES),
    localparam int RW = LW + 1
) (
    input  logic [NUM_LINES-1:0] vec,
    input  logic [LW-1:0]        base,
    output logic [RW-1:0]        rel
);

    logic [NUM_LINES-1:0] rot;

    for (genvar p = 0; p < NUM_LINES; p++) begin : g_rot
        assign rot[p] = vec[LW'(p + int'(base))];
    end

    always_comb begin
        rel = RW'(NUM_LINES);
        for (int p = NUM_LINES - 1; p >= 0; p--) begin
            if (rot[p]) rel = RW'(p);
        end
    end

endmodule

// File: rtl/svc_ctrl.sv
// Holds the in-service register, the priority base and the rotate flag;
// executes service commands and acknowledges.
module svc_ctrl import prio_res_pkg::*; #(
    parameter int NUM_LINES = 8,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [CMD_W-1:0]     cmd_byte,
    input  logic                 ack_ok,
    input  logic [LW-1:0]        ack_line,
    input  logic                 top_hit,
    input  logic [LW-1:0]        top_line,
    output logic [NUM_LINES-1:0] isr_q,
    output logic [LW-1:0]        base_q,
    output logic                 rot_q
);

    svc_cmd_t             cmd;
    logic [NUM_LINES-1:0] clr_vec, set_vec, isr_n;
    logic [LW-1:0]        base_n, arg_l;
    logic                 rot_n;

    assign cmd   = decode_cmd(cmd_byte);
    assign arg_l = LW'(cmd.arg);

    always_comb begin
        clr_vec = '0;
        base_n  = base_q;
        rot_n   = rot_q;
        if (cmd_valid && cmd.fmt_ok) begin
            unique case (cmd.op)
                OP_ROT_OFF, OP_ROT_ON: rot_n = (cmd.op == OP_ROT_ON);
                OP_EOI_TOP, OP_EOI_TOP_R: begin
                    if (top_hit) begin
                        clr_vec[top_line] = 1'b1;
                        if (cmd.op == OP_EOI_TOP_R) base_n = top_line + LW'(1);
                    end
                end
                OP_EOI_LINE: clr_vec[arg_l] = 1'b1;
                OP_EOI_LINE_R: begin
                    clr_vec[arg_l] = 1'b1;
                    base_n         = arg_l + LW'(1);
                end
                OP_SET_BASE: base_n = arg_l + LW'(1);
                OP_IDLE: ;
            endcase
        end
    end

    always_comb begin
        set_vec = '0;
        if (ack_ok) set_vec[ack_line] = 1'b1;
        isr_n = (isr_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q  <= '0;
            base_q <= '0;
            rot_q  <= 1'b0;
        end else begin
            isr_q  <= isr_n;
            base_q <= base_n;
            rot_q  <= rot_n;
        end
    end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver import prio_res_pkg::*; #(
    parameter int NUM_LINES    = DEF_LINES,
    parameter int CASCADE_LINE = 2,
    localparam int LW = $clog2(NUM_LINES),
    localparam int RW = LW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 cmd_valid_i,
    input  logic [CMD_W-1:0]     cmd_i,
    input  logic                 ack_i,
    input  logic                 nested_i,
    input  logic                 primary_i,
    output logic                 irq_valid_o,
    output logic [LW-1:0]        irq_line_o,
    output logic [NUM_LINES-1:0] isr_o,
    output logic                 rot_aeoi_o
);

    logic [NUM_LINES-1:0] req_vec, isr_q, isr_eff;
    logic [LW-1:0]        base_q, win_line, top_line;
    logic [RW-1:0]        req_rel, cur_rel, top_rel;
    logic                 win, top_hit;

    assign req_vec = pend_i & ~mask_i;

    // cascade-line exclusion for the current-priority comparison
    if (CASCADE_LINE >= 0 && CASCADE_LINE < NUM_LINES) begin : g_casc
        logic [NUM_LINES-1:0] excl;
        always_comb begin
            excl = '0;
            if (nested_i && primary_i) excl[CASCADE_LINE] = 1'b1;
        end
        assign isr_eff = isr_q & ~excl;
    end else begin : g_nocasc
        assign isr_eff = isr_q;
    end

    prio_scan #(.NUM_LINES(NUM_LINES)) u_scan_req (
        .vec  (req_vec),
        .base (base_q),
        .rel  (req_rel)
    );

    prio_scan #(.NUM_LINES(NUM_LINES)) u_scan_cur (
        .vec  (isr_eff),
        .base (base_q),
        .rel  (cur_rel)
    );

    prio_scan #(.NUM_LINES(NUM_LINES)) u_scan_top (
        .vec  (isr_q),
        .base (base_q),
        .rel  (top_rel)
    );

    assign win      = (req_rel < cur_rel);
    assign win_line = req_rel[LW-1:0] + base_q;
    assign top_hit  = (top_rel != RW'(NUM_LINES));
    assign top_line = top_rel[LW-1:0] + base_q;

    svc_ctrl #(.NUM_LINES(NUM_LINES)) u_svc (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid_i),
        .cmd_byte  (cmd_i),
        .ack_ok    (ack_i && irq_valid_o),
        .ack_line  (irq_line_o),
        .top_hit   (top_hit),
        .top_line  (top_line),
        .isr_q     (isr_q),
        .base_q    (base_q),
        .rot_q     (rot_aeoi_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid_o <= 1'b0;
            irq_line_o  <= '0;
        end else begin
            irq_valid_o <= win;
            irq_line_o  <= win ? win_line : '0;
        end
    end

    assign isr_o = isr_q;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk import prio_res_pkg::*; #(
    parameter int NUM_LINES = DEF_LINES,
    localparam int LW = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] pend_i,
    input logic [NUM_LINES-1:0] mask_i,
    input logic                 cmd_valid_i,
    input logic [CMD_W-1:0]     cmd_i,
    input logic                 ack_i,
    input logic                 nested_i,
    input logic                 primary_i,
    input logic                 irq_valid_o,
    input logic [LW-1:0]        irq_line_o,
    input logic [NUM_LINES-1:0] isr_o,
    input logic                 rot_aeoi_o
);

    logic [NUM_LINES-1:0] req_d, isr_d;
    logic                 excl_d;

    always_ff @(posedge clk) begin
        req_d  <= pend_i & ~mask_i;
        isr_d  <= isr_o;
        excl_d <= nested_i && primary_i;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (isr_o == '0 && !irq_valid_o && !rot_aeoi_o));

    // R2
    winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> req_d[irq_line_o]);

    // R3
    no_reentry_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid_o && !excl_d) |-> !isr_d[irq_line_o]);

    // R12
    ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_valid_o) |=> isr_o[$past(irq_line_o)]);

    // R11
    isr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid_i && !ack_i) |=> $stable(isr_o));

    // R9
    line_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_i[7:5] == 3'd3 && cmd_i[4:3] == 2'b00 && !ack_i)
        |=> !isr_o[$past(cmd_i[2:0])]);

    // R10
    base_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_i[7:5] == 3'd6 && !ack_i) |=> $stable(isr_o));

endmodule

bind prio_resolver prio_resolver_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend_i),
    .mask_i      (mask_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .ack_i       (ack_i),
    .nested_i    (nested_i),
    .primary_i   (primary_i),
    .irq_valid_o (irq_valid_o),
    .irq_line_o  (irq_line_o),
    .isr_o       (isr_o),
    .rot_aeoi_o  (rot_aeoi_o)
);

// File: tb/test_prio_resolver.sv
`timescale 1ns/1ps
module test_prio_resolver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pend = '0, mask = '0, cmd = '0;
    logic       cmd_valid = 1'b0, ack = 1'b0, nested = 1'b0, primary = 1'b0;
    logic       irq_valid, rot_aeoi;
    logic [2:0] irq_line;
    logic [7:0] isr;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    string cur_tag = "R1";

    // reference model state
    int m_isr, m_base, m_rot, m_valid, m_line;

    always #2 clk = ~clk;

    prio_resolver i_prio_resolver (
        .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask),
        .cmd_valid_i(cmd_valid), .cmd_i(cmd), .ack_i(ack),
        .nested_i(nested), .primary_i(primary),
        .irq_valid_o(irq_valid), .irq_line_o(irq_line),
        .isr_o(isr), .rot_aeoi_o(rot_aeoi)
    );

    function automatic int top_rel(int vec, int base);
        for (int p = 0; p < 8; p++)
            if ((vec >> ((p + base) % 8)) & 1) return p;
        return 8;
    endfunction

    task automatic model_step();
        int rq, cur, eff, clr, st, c, n, t, nb, nr, l;
        if (rst) begin
            m_isr = 0; m_base = 0; m_rot = 0; m_valid = 0; m_line = 0;
            return;
        end
        eff = m_isr;
        if (nested && primary) eff = eff & ~4;
        rq  = top_rel(int'(pend & ~mask), m_base);
        cur = top_rel(eff, m_base);
        clr = 0; nb = m_base; nr = m_rot;
        if (cmd_valid && (cmd & 8'h18) == 0) begin
            c = int'(cmd) >> 5;
            n = int'(cmd) & 7;
            case (c)
                0, 4: nr = c >> 2;
                1, 5: begin
                    t = top_rel(m_isr, m_base);
                    if (t != 8) begin
                        l = (t + m_base) % 8;
                        clr = 1 << l;
                        if (c == 5) nb = (l + 1) % 8;
                    end
                end
                3: clr = 1 << n;
                7: begin clr = 1 << n; nb = (n + 1) % 8; end
                6: nb = (n + 1) % 8;
                default: ;
            endcase
        end
        st = (ack && m_valid != 0) ? (1 << m_line) : 0;
        m_isr   = ((m_isr & ~clr) | st) & 8'hFF;
        m_valid = (rq < cur) ? 1 : 0;
        m_line  = (rq < cur) ? (rq + m_base) % 8 : 0;
        m_base  = nb;
        m_rot   = nr;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(cur_tag, "irq_valid", int'(irq_valid), m_valid);
        chk(cur_tag, "irq_line", int'(irq_line), m_line);
        chk(cur_tag, "isr", int'(isr), m_isr);
        chk(cur_tag, "rot_aeoi", int'(rot_aeoi), m_rot);
    endtask

    task automatic step(input logic [7:0] p, input logic [7:0] m,
                        input logic cv, input logic [7:0] c, input logic a,
                        input logic ne, input logic pr);
        @(negedge clk);
        pend = p; mask = m; cmd_valid = cv; cmd = c; ack = a;
        nested = ne; primary = pr;
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic expect_out(string tag, int v, int l, int i);
        chk(tag, "irq_valid", int'(irq_valid), v);
        chk(tag, "irq_line", int'(irq_line), l);
        chk(tag, "isr", int'(isr), i);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_step();
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1", 0, 0, 0);
        chk("R1", "rot_aeoi", int'(rot_aeoi), 0);
        @(negedge clk);
        rst = 1'b0;

        cur_tag = "R2";
        step(8'h30, 8'h00, 0, 8'h00, 0, 0, 0);
        expect_out("R2", 1, 4, 8'h00);
        step(8'h30, 8'h10, 0, 8'h00, 0, 0, 0);
        expect_out("R2 masked", 1, 5, 8'h00);

        cur_tag = "R5";
        step(8'h30, 8'h10, 0, 8'h00, 1, 0, 0);
        expect_out("R5", 1, 5, 8'h20);
        cur_tag = "R3";
        step(8'h30, 8'h10, 0, 8'h00, 0, 0, 0);
        expect_out("R3 equal", 0, 0, 8'h20);
        step(8'h38, 8'h10, 0, 8'h00, 0, 0, 0);
        expect_out("R3 outranks", 1, 3, 8'h20);
        cur_tag = "R6";
        step(8'h38, 8'h10, 0, 8'h00, 1, 0, 0);
        step(8'h38, 8'h10, 0, 8'h00, 0, 0, 0);
        expect_out("R6", 0, 0, 8'h28);
        step(8'h38, 8'h10, 0, 8'h00, 1, 0, 0);
        expect_out("R6 ack idle", 0, 0, 8'h28);

        cur_tag = "R7";
        step(8'h38, 8'h10, 1, 8'h20, 0, 0, 0);
        step(8'h38, 8'h10, 0, 8'h00, 0, 0, 0);
        expect_out("R7", 1, 3, 8'h20);

        cur_tag = "R9";
        step(8'h38, 8'h10, 1, 8'h60, 0, 0, 0);
        expect_out("R9 other", 1, 3, 8'h20);
        step(8'h38, 8'h10, 1, 8'h65, 0, 0, 0);
        chk("R9", "isr", int'(isr), 0);

        cur_tag = "R10";
        step(8'h38, 8'h10, 1, 8'hC3, 0, 0, 0);
        step(8'h38, 8'h10, 0, 8'h00, 0, 0, 0);
        expect_out("R10", 1, 5, 8'h00);

        cur_tag = "R8";
        step(8'h38, 8'h10, 0, 8'h00, 1, 0, 0);
        step(8'hFF, 8'h00, 1, 8'hA0, 0, 0, 0);
        step(8'hFF, 8'h00, 0, 8'h00, 0, 0, 0);
        expect_out("R8", 1, 6, 8'h00);
        step(8'hFF, 8'h00, 1, 8'hA0, 0, 0, 0);
        step(8'hFF, 8'h00, 0, 8'h00, 0, 0, 0);
        expect_out("R8 empty", 1, 6, 8'h00);

        cur_tag = "R9";
        step(8'hFF, 8'h00, 1, 8'hE1, 0, 0, 0);
        step(8'hFF, 8'h00, 0, 8'h00, 0, 0, 0);
        expect_out("R9 rotate", 1, 2, 8'h00);

        cur_tag = "R4";
        step(8'h04, 8'h00, 1, 8'hC7, 0, 1, 1);
        step(8'h04, 8'h00, 0, 8'h00, 1, 1, 1);
        step(8'h04, 8'h00, 0, 8'h00, 0, 1, 1);
        expect_out("R4 nested", 1, 2, 8'h04);
        step(8'h04, 8'h00, 0, 8'h00, 0, 1, 0);
        expect_out("R4 secondary", 0, 0, 8'h04);

        cur_tag = "R11";
        step(8'h04, 8'h00, 1, 8'h80, 0, 0, 0);
        chk("R11 set", "rot_aeoi", int'(rot_aeoi), 1);
        step(8'h04, 8'h00, 1, 8'h40, 0, 0, 0);
        step(8'h04, 8'h00, 1, 8'h10, 0, 0, 0);
        step(8'h04, 8'h00, 1, 8'h08, 0, 0, 0);
        step(8'h04, 8'h00, 0, 8'h00, 0, 0, 0);
        chk("R11 ignored", "rot_aeoi", int'(rot_aeoi), 1);
        step(8'h04, 8'h00, 1, 8'h7A, 0, 0, 0);
        step(8'h04, 8'h00, 0, 8'h62, 0, 0, 0);
        chk("R11 ignored", "isr", int'(isr), 8'h04);
        step(8'h04, 8'h00, 1, 8'h00, 0, 0, 0);
        chk("R11 clear", "rot_aeoi", int'(rot_aeoi), 0);

        cur_tag = "R12";
        step(8'h02, 8'h00, 1, 8'h62, 0, 0, 0);
        step(8'h02, 8'h00, 1, 8'h61, 1, 0, 0);
        chk("R12 same line", "isr", int'(isr), 8'h02);
        step(8'h03, 8'h00, 0, 8'h00, 0, 0, 0);
        expect_out("R12 setup", 1, 0, 8'h02);
        step(8'h03, 8'h00, 1, 8'h20, 1, 0, 0);
        chk("R12 eoi+ack", "isr", int'(isr), 8'h01);

        cur_tag = "R5 R12 random";
        for (int k = 0; k < 600; k++) begin
            logic [7:0] rc;
            rc = 8'($urandom);
            if ($urandom_range(0, 3) != 0) rc = rc & 8'hE7;
            step(8'($urandom), 8'($urandom) & 8'($urandom),
                 ($urandom_range(0, 2) == 0), rc,
                 ($urandom_range(0, 2) == 0),
                 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule